// File: doc/BRIEF.md
# Synchronous Trap Double-Fault Status Register

This block is one control/status register of a small processor core. It records whether a synchronous exception has been taken and whether its handler has not yet returned. If a second synchronous exception arrives in that window, the block raises a sticky double-fault flag. The core's trap logic drives three single-cycle pulses into the block:

- an exception-entry pulse;
- a pulse for an mret that retires without trapping;
- an NMI-entry pulse.

Software reads and writes the whole register through a plain CSR port.

The register is nine bits wide. Bit 6 is the "exception pending" bit and bit 7 is the "double fault" bit. The other seven bits are plain storage that only software writes. A separate flag records whether the core is in NMI mode, and a returning mret clears that flag.

All state is registered. An event or write applied in one cycle shows on the outputs after the next rising clock edge. There is no data stream here, so every pin is a plain control or status signal with no handshake.

Top module: `fault_status_csr`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `csr_rdata_o` is 9'h000, and `double_fault_o` and `nmi_mode_o` are 0.
- R2: An exception-entry pulse sets bit 6 on the next cycle. With no write in the same cycle, every bit other than 6 and 7 keeps its value.
- R3: An exception-entry pulse that arrives while bit 6 is already 1 sets bit 7 in the same update.
- R4: An mret-retire pulse clears bit 6 and leaves bit 7 unchanged. Bit 7 is sticky and only a software write can clear it.
- R5: A CSR write with no hardware event in that cycle loads all nine bits from `csr_wdata_i` on the next cycle.
- R6: When a CSR write and an exception-entry or mret-retire pulse share a cycle, the hardware result is used for bits 6 and 7. The written value is used for all other bits.
- R7: An NMI-entry pulse sets `nmi_mode_o` on the next cycle. Exception-entry pulses do not change `nmi_mode_o`.
- R8: An mret-retire pulse clears `nmi_mode_o` on the next cycle, unless an NMI-entry pulse arrives in the same cycle, in which case `nmi_mode_o` is 1.
- R9: `double_fault_o` always equals bit 7 of `csr_rdata_o`.
- R10: The exception-entry and mret-retire pulses are never both high in one cycle. Callers must keep them exclusive.
- R11: An exception-entry pulse that arrives while bit 6 is 0 does not change bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_enter_i | input | 1 | Synchronous exception entry, one-cycle pulse |
| mret_retire_i | input | 1 | Non-trapping mret retired, one-cycle pulse |
| nmi_enter_i | input | 1 | NMI entry, one-cycle pulse |
| csr_we_i | input | 1 | Software write strobe |
| csr_wdata_i | input | 9 | Software write data |
| csr_rdata_o | output | 9 | Current register contents |
| double_fault_o | output | 1 | Double fault flag (bit 7) |
| nmi_mode_o | output | 1 | Core is in NMI mode |

## Verification
Every result in this block is due exactly one clock edge after its stimulus. This holds for the bit 6 and 7 updates, the software-written bits and the NMI-mode flag, because each passes through a single register stage and has no combinational path from input to output.

The driver applies one cycle of pulses at the falling edge. It computes that cycle's expected register, flag and mode values from the requirements and queues them. The monitor takes one entry from the queue shortly after each following rising edge and compares it, so each check lands on the cycle its result first appears.

// File: rtl/fault_status_pkg.sv
package fault_status_pkg;
  parameter int unsigned CSR_W_DEF    = 9;
  parameter int unsigned SEEN_IDX_DEF = 6;
  parameter int unsigned DF_IDX_DEF   = 7;

  typedef struct packed {
    logic exc;
    logic mret;
  } hw_event_t;

  typedef struct packed {
    logic active;
    logic seen;
    logic df;
  } hw_update_t;
endpackage

// File: rtl/fds_status_bits.sv
module fds_status_bits
  import fault_status_pkg::*;
(
  input  hw_event_t  evt_i,
  input  logic       seen_q_i,
  input  logic       df_q_i,
  output hw_update_t upd_o
);
  always_comb begin
    upd_o.active = evt_i.exc | evt_i.mret;
    upd_o.seen   = seen_q_i;
    upd_o.df     = df_q_i;
    if (evt_i.exc) begin
      upd_o.seen = 1'b1;
      upd_o.df   = df_q_i | seen_q_i;
    end else if (evt_i.mret) begin
      upd_o.seen = 1'b0;
    end
  end
endmodule

// File: rtl/fds_csr_store.sv
module fds_csr_store
  import fault_status_pkg::*;
#(
  parameter int unsigned CSR_W    = CSR_W_DEF,
  parameter int unsigned SEEN_IDX = SEEN_IDX_DEF,
  parameter int unsigned DF_IDX   = DF_IDX_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  hw_update_t       upd_i,
  output logic [CSR_W-1:0] q_o
);
  logic [CSR_W-1:0] q, nxt;

  for (genvar i = 0; i < CSR_W; i++) begin : g_bit
    if (i == SEEN_IDX) begin : g_seen
      assign nxt[i] = upd_i.active ? upd_i.seen : (we_i ? wdata_i[i] : q[i]);
    end else if (i == DF_IDX) begin : g_df
      assign nxt[i] = upd_i.active ? upd_i.df : (we_i ? wdata_i[i] : q[i]);
    end else begin : g_plain
      assign nxt[i] = we_i ? wdata_i[i] : q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/fds_nmi_tracker.sv
module fds_nmi_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_enter_i,
  input  logic mret_i,
  output logic nmi_mode_o
);
  logic mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (nmi_enter_i)  mode_d = 1'b1;
    else if (mret_i)  mode_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_d;
  end

  assign nmi_mode_o = mode_q;
endmodule

// File: rtl/fault_status_csr.sv
module fault_status_csr
  import fault_status_pkg::*;
#(
  parameter int unsigned CSR_W    = CSR_W_DEF,
  parameter int unsigned SEEN_IDX = SEEN_IDX_DEF,
  parameter int unsigned DF_IDX   = DF_IDX_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_enter_i,
  input  logic             mret_retire_i,
  input  logic             nmi_enter_i,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [CSR_W-1:0] csr_rdata_o,
  output logic             double_fault_o,
  output logic             nmi_mode_o
);
  hw_event_t        evt;
  hw_update_t       upd;
  logic [CSR_W-1:0] reg_q;

  assign evt.exc  = exc_enter_i;
  assign evt.mret = mret_retire_i;

  fds_status_bits u_bits (
    .evt_i    (evt),
    .seen_q_i (reg_q[SEEN_IDX]),
    .df_q_i   (reg_q[DF_IDX]),
    .upd_o    (upd)
  );

  fds_csr_store #(
    .CSR_W    (CSR_W),
    .SEEN_IDX (SEEN_IDX),
    .DF_IDX   (DF_IDX)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i),
    .wdata_i (csr_wdata_i),
    .upd_i   (upd),
    .q_o     (reg_q)
  );

  fds_nmi_tracker u_nmi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nmi_enter_i (nmi_enter_i),
    .mret_i      (mret_retire_i),
    .nmi_mode_o  (nmi_mode_o)
  );

  assign csr_rdata_o    = reg_q;
  assign double_fault_o = reg_q[DF_IDX];
endmodule

// File: rtl/fault_status_csr_chk.sv
module fault_status_csr_chk #(
  parameter int unsigned CSR_W    = 9,
  parameter int unsigned SEEN_IDX = 6,
  parameter int unsigned DF_IDX   = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             exc_enter_i,
  input logic             mret_retire_i,
  input logic             nmi_enter_i,
  input logic             csr_we_i,
  input logic [CSR_W-1:0] csr_wdata_i,
  input logic [CSR_W-1:0] csr_rdata_o,
  input logic             double_fault_o,
  input logic             nmi_mode_o
);
  localparam logic [CSR_W-1:0] ONE = {{(CSR_W-1){1'b0}}, 1'b1};
  localparam logic [CSR_W-1:0] KEEP_MASK = ~((ONE << SEEN_IDX) | (ONE << DF_IDX));

  AST_EXC_SETS_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_enter_i |=> csr_rdata_o[SEEN_IDX]); // R2
  AST_OTHERS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((exc_enter_i || mret_retire_i) && !csr_we_i) |=>
      ((csr_rdata_o & KEEP_MASK) == ($past(csr_rdata_o) & KEEP_MASK))); // R2
  AST_DOUBLE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_enter_i && csr_rdata_o[SEEN_IDX]) |=> double_fault_o); // R3
  AST_MRET_CLEARS_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_retire_i |=> !csr_rdata_o[SEEN_IDX]); // R4
  AST_DF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_retire_i && csr_rdata_o[DF_IDX]) |=> csr_rdata_o[DF_IDX]); // R4
  AST_SW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !exc_enter_i && !mret_retire_i) |=> (csr_rdata_o == $past(csr_wdata_i))); // R5
  AST_WRITE_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && (exc_enter_i || mret_retire_i)) |=>
      ((csr_rdata_o & KEEP_MASK) == ($past(csr_wdata_i) & KEEP_MASK))); // R6
  AST_NMI_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_enter_i |=> nmi_mode_o); // R7
  AST_NMI_LEAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_retire_i && !nmi_enter_i) |=> !nmi_mode_o); // R8
  AST_EXC_MRET_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_enter_i && mret_retire_i)); // R10
  AST_NO_SPURIOUS_DF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_enter_i && !csr_rdata_o[SEEN_IDX] && !csr_we_i) |=> $stable(double_fault_o)); // R11
endmodule

bind fault_status_csr fault_status_csr_chk #(
  .CSR_W    (CSR_W),
  .SEEN_IDX (SEEN_IDX),
  .DF_IDX   (DF_IDX)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .exc_enter_i    (exc_enter_i),
  .mret_retire_i  (mret_retire_i),
  .nmi_enter_i    (nmi_enter_i),
  .csr_we_i       (csr_we_i),
  .csr_wdata_i    (csr_wdata_i),
  .csr_rdata_o    (csr_rdata_o),
  .double_fault_o (double_fault_o),
  .nmi_mode_o     (nmi_mode_o)
);

// File: tb/fault_status_csr_tb.sv
`timescale 1ns/1ps
module fault_status_csr_tb;
  localparam int W = 9;

  typedef struct {
    logic [W-1:0] rdata;
    logic         df;
    logic         nmi;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         exc = 1'b0, mret = 1'b0, nmi_in = 1'b0, we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         df_o, nmi_o;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  logic [W-1:0] m_reg = '0;
  logic         m_nmi = 1'b0;
  bit           done = 0;

  always #2.5 clk = ~clk;

  fault_status_csr u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .exc_enter_i    (exc),
    .mret_retire_i  (mret),
    .nmi_enter_i    (nmi_in),
    .csr_we_i       (we),
    .csr_wdata_i    (wdata),
    .csr_rdata_o    (rdata),
    .double_fault_o (df_o),
    .nmi_mode_o     (nmi_o)
  );

  function automatic void compare(exp_t e);
    checks++;
    if (rdata !== e.rdata || df_o !== e.df || nmi_o !== e.nmi) begin
      fails++;
      $display("FAIL %s: rdata=%h df=%b nmi=%b expected rdata=%h df=%b nmi=%b",
               e.tag, rdata, df_o, nmi_o, e.rdata, e.df, e.nmi);
    end
  endfunction

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic e, input logic m, input logic n,
                      input logic w, input logic [W-1:0] d, input string tag);
    logic [W-1:0] nr;
    exp_t it;
    @(negedge clk);
    exc = e; mret = m; nmi_in = n; we = w; wdata = d;
    nr = w ? d : m_reg;
    if (e) begin
      nr[6] = 1'b1;
      nr[7] = m_reg[7] | m_reg[6];
    end else if (m) begin
      nr[6] = 1'b0;
      nr[7] = m_reg[7];
    end
    m_nmi = n ? 1'b1 : (m ? 1'b0 : m_nmi);
    m_reg = nr;
    it.rdata = nr; it.df = nr[7]; it.nmi = m_nmi; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: result is due one edge after the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.rdata = '0; r.df = 0; r.nmi = 0; r.tag = "R1 in reset";
    compare(r);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, '0, "R1 after reset");
    step(0, 0, 0, 1, 9'h1A5, "R5 write all bits");
    step(0, 0, 0, 0, '0, "R9 flag follows bit 7");
    step(0, 0, 0, 1, 9'h105, "R5 rewrite clears bit 7");
    step(1, 0, 0, 0, '0, "R2 R11 first exception");
    step(0, 1, 0, 0, '0, "R4 mret clears pending");
    step(1, 0, 0, 0, '0, "R2 exception again");
    step(1, 0, 0, 0, '0, "R3 nested exception");
    step(0, 1, 0, 0, '0, "R4 bit 7 sticky over mret");
    step(1, 0, 0, 0, '0, "R11 exception with bit 7 set");
    step(0, 0, 0, 1, 9'h000, "R4 software clears bit 7");
    step(1, 0, 0, 1, 9'h0AA, "R6 write with exception");
    step(0, 1, 0, 1, 9'h1C3, "R6 write with mret");
    step(1, 0, 0, 1, 9'h0FF, "R6 write with exception, bits 6/7 hw");
    step(1, 0, 0, 1, 9'h000, "R6 R3 write cannot mask double fault");
    step(0, 0, 1, 0, '0, "R7 nmi entry");
    step(1, 0, 0, 0, '0, "R7 exception keeps nmi mode");
    step(0, 1, 0, 0, '0, "R8 mret leaves nmi");
    step(0, 0, 1, 0, '0, "R7 nmi entry again");
    step(0, 1, 1, 0, '0, "R8 nmi entry with mret stays");
    step(0, 1, 0, 0, '0, "R8 mret leaves nmi");
    for (int i = 0; i < 60; i++) begin
      int sel;
      sel = $urandom_range(0, 5);
      step(sel == 0 || sel == 1, sel == 2, $urandom_range(0, 7) == 0,
           $urandom_range(0, 3) == 0, W'($urandom), "R9 R10 mixed traffic");
    end
    step(0, 0, 0, 0, '0, "R9 idle");
    @(negedge clk);
    exc = 0; mret = 0; nmi_in = 0; we = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule